// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches a 32-bit digital input bus and raises one level-sensitive interrupt request when any input toggles, whether it rises or falls, provided detection is enabled. The inputs arrive from outside the clock domain. Each one passes through a two-flop synchroniser. The synchronised word is then compared with the word from the clock before, so every toggle yields exactly one detection event.

Software drives the block through a 16-bit write-only control word. Bit 8 holds the detection enable and bit 0 is a write-one-to-clear strobe for the pending interrupt. The block keeps a single pending flag, and the interrupt output is that flag registered once more. A change that occurs while the flag is already set is discarded and is not queued. Software therefore services one event, writes the clear, and only later changes can raise a new request.

Top module: `cos_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `irq` is 0 and detection is disabled. The control word resets to 0x0000.
- R2: With detection enabled, a toggle of one or more input bits raises `irq` exactly four rising clock edges after the input changes: two synchroniser stages, one compare stage and the output register. A toggle of several bits in the same cycle produces a single request.
- R3: A falling transition (1 to 0) on any of the 32 inputs raises `irq` in the same way as a rising one.
- R4: While bit 8 of the control word is 0, input changes do not set the pending flag. Those changes are lost and do not appear when detection is enabled again.
- R5: A write with bit 0 = 1 clears the pending flag at the write edge, and `irq` falls one clock later.
- R6: A write with bit 0 = 0 leaves the pending flag unchanged. Writing bit 8 = 0 while a request is pending does not clear it.
- R7: While a request is pending, further input changes are ignored. After the clear they leave no request behind.
- R8: Bits 15 to 9 and bits 7 to 1 of the control word have no effect on the enable, the clear or the output.
- R9: If a clear write and a detected change fall in the same clock cycle, the clear wins and that change is dropped.
- R10: A single toggle is detected only once. A steady input does not raise a new request after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| din | input | 32 | Asynchronous digital inputs being watched |
| wr_en | input | 1 | Control word write strobe, one cycle per write |
| wr_data | input | 16 | Control word: bit 8 enable, bit 0 clear strobe |
| irq | output | 1 | Interrupt request level, high while an event is pending |

## Verification
A wrong pending flag shows on `irq` one clock after the flag goes wrong. It appears either as a request that stays high after a clear or as a request that never comes. Faults in the synchroniser or in the compare register show up as a shifted rise latency, as a missed rise or fall on a particular input bit, or as a second request from one toggle. These show within four to six cycles of the stimulus. The sweep over every bit in both directions, the timed collision of a clear and an event, and the writes with the unused bits set expose each of these faults at the output pin.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;

  localparam int unsigned CTRL_WIDTH = 16;
  localparam int unsigned EN_POS     = 8;
  localparam int unsigned CLR_POS    = 0;

  typedef struct packed {
    logic en_load;
    logic en_val;
    logic clr;
  } ctrl_cmd_t;

endpackage

// File: rtl/cos_rst_sync.sv
module cos_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cos_in_sync.sv
module cos_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = async_in;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cos_edge_det.sv
module cos_edge_det #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  output logic             chg_any
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;
  logic [WIDTH-1:0] diff;
  logic             prev_ce;

  // The compare register loads every cycle, so each toggle is seen once.
  assign prev_ce = 1'b1;

  always_comb begin
    prev_d = prev_q;
    if (prev_ce) begin
      prev_d = cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      diff[i] = cur[i] ^ prev_q[i];
    end
  end

  assign chg_any = |diff;

endmodule

// File: rtl/cos_ctrl_dec.sv
module cos_ctrl_dec
  import cos_irq_pkg::*;
#(
  parameter int unsigned WIDTH = CTRL_WIDTH,
  parameter int unsigned EN_B  = EN_POS,
  parameter int unsigned CLR_B = CLR_POS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             en_q,
  output logic             clr_pulse
);

  localparam logic [WIDTH-1:0] LIVE_MASK = (WIDTH'(1) << EN_B) | (WIDTH'(1) << CLR_B);

  logic [WIDTH-1:0] live_bits;
  ctrl_cmd_t        cmd;
  logic             en_d;

  always_comb begin
    live_bits   = wr_data & LIVE_MASK;
    cmd.en_load = wr_en;
    cmd.en_val  = live_bits[EN_B];
    cmd.clr     = wr_en & live_bits[CLR_B];
  end

  always_comb begin
    en_d = en_q;
    if (cmd.en_load) begin
      en_d = cmd.en_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign clr_pulse = cmd.clr;

endmodule

// File: rtl/cos_pend.sv
module cos_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic chg,
  input  logic clr,
  output logic pend_q,
  output logic irq_q
);

  logic pend_d;
  logic set_ev;
  logic pend_ce;

  assign set_ev  = en & chg & ~pend_q;
  assign pend_ce = clr | set_ev;

  always_comb begin
    pend_d = pend_q;
    if (pend_ce) begin
      // clear takes priority over a same-cycle event
      pend_d = ~clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_q;
    end
  end

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_irq_pkg::*;
#(
  parameter int unsigned DIN_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned CW          = CTRL_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIN_W-1:0] din,
  input  logic             wr_en,
  input  logic [CW-1:0]    wr_data,
  output logic             irq
);

  logic             rst_sync_n;
  logic [DIN_W-1:0] din_s;
  logic             chg_any;
  logic             en_q;
  logic             clr_pulse;
  logic             pend_q;

  cos_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cos_in_sync #(.WIDTH(DIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (din),
    .sync_out (din_s)
  );

  cos_edge_det #(.WIDTH(DIN_W)) u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cur     (din_s),
    .chg_any (chg_any)
  );

  cos_ctrl_dec #(.WIDTH(CW), .EN_B(EN_POS), .CLR_B(CLR_POS)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .en_q      (en_q),
    .clr_pulse (clr_pulse)
  );

  cos_pend u_pend (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (en_q),
    .chg    (chg_any),
    .clr    (clr_pulse),
    .pend_q (pend_q),
    .irq_q  (irq)
  );

endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [CW-1:0] wr_data,
  input logic          irq,
  input logic          pend_q,
  input logic          en_q,
  input logic          chg_any
);

  // R1: output low while reset is held
  p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !irq);

  // R5: a clear write brings irq low two edges later
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0]) |=> ##1 !irq);

  // R7: a request stays until a clear is written
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(wr_en && wr_data[0])) |=> pend_q);

  // R4: the flag is set only while detection is enabled
  p_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(en_q));

  // R2: the flag is set only by a detected change, and reaches irq next cycle
  p_needs_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(chg_any));

  p_irq_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |=> irq);

endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .irq     (irq),
  .pend_q  (pend_q),
  .en_q    (en_q),
  .chg_any (chg_any)
);

// File: tb/cos_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cos_irq_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] din;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        irq;

  int checks;
  int errors;
  bit done;

  cos_irq_ctrl u_cos_irq_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .irq     (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic toggle(input logic [31:0] m);
    @(negedge clk);
    din = din ^ m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    din     = '0;
    wr_en   = 1'b0;
    wr_data = '0;
    idle(3);
    check("R1", irq, 1'b0);
    rst_n = 1'b1;
    idle(4);
    check("R1", irq, 1'b0);

    // R1: disabled after reset, a toggle does nothing
    toggle(32'h1);
    idle(6);
    check("R1", irq, 1'b0);

    // R2: exact latency of four edges
    wr(16'h0100);
    idle(2);
    toggle(32'h1);
    idle(3);
    check("R2", irq, 1'b0);
    idle(1);
    check("R2", irq, 1'b1);
    wr(16'h0101);
    idle(2);
    check("R5", irq, 1'b0);

    // R2/R3/R5/R10: every bit, rising then falling
    for (int pass = 0; pass < 2; pass++) begin
      for (int b = 0; b < 32; b++) begin
        toggle(32'h1 << b);
        idle(6);
        check(pass == 0 ? "R2" : "R3", irq, 1'b1);
        wr(16'h0101);
        idle(2);
        check("R5", irq, 1'b0);
        idle(6);
        check("R10", irq, 1'b0);
      end
    end

    // R2: many bits at once give one request
    toggle(32'hFFFF_FFFF);
    idle(6);
    check("R2", irq, 1'b1);
    wr(16'h0101);
    idle(8);
    check("R2", irq, 1'b0);

    // R4: disabled, changes on every bit are lost
    wr(16'h0000);
    for (int b = 0; b < 32; b++) begin
      toggle(32'h1 << b);
      idle(6);
      check("R4", irq, 1'b0);
    end
    wr(16'h0100);
    idle(8);
    check("R4", irq, 1'b0);

    // R7: change while pending is dropped
    toggle(32'h8);
    idle(6);
    check("R7", irq, 1'b1);
    toggle(32'h80);
    idle(6);
    check("R7", irq, 1'b1);
    wr(16'h0101);
    idle(8);
    check("R7", irq, 1'b0);

    // R6: clear bit 0, or enable 0, does not clear
    toggle(32'h10);
    idle(6);
    check("R6", irq, 1'b1);
    wr(16'h0100);
    idle(3);
    check("R6", irq, 1'b1);
    wr(16'h0000);
    idle(3);
    check("R6", irq, 1'b1);
    wr(16'h0001);
    idle(3);
    check("R5", irq, 1'b0);
    toggle(32'h10);
    idle(6);
    check("R4", irq, 1'b0);

    // R8: reserved bits ignored
    wr(16'h01FE);
    toggle(32'h20);
    idle(6);
    check("R8", irq, 1'b1);
    wr(16'hFFFE);
    idle(3);
    check("R8", irq, 1'b1);
    wr(16'hFEFF);
    idle(3);
    check("R8", irq, 1'b0);
    toggle(32'h20);
    idle(6);
    check("R8", irq, 1'b0);
    wr(16'hFE00);
    toggle(32'h40);
    idle(6);
    check("R8", irq, 1'b0);

    // R9: clear in the same cycle as the detected change
    wr(16'h0100);
    idle(2);
    toggle(32'h100);
    @(negedge clk);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = 16'h0101;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
    idle(6);
    check("R9", irq, 1'b0);
    toggle(32'h100);
    idle(6);
    check("R9", irq, 1'b1);

    finish_run();
  end

endmodule